// File: doc/BRIEF.md
# Masked Interrupt Flag and Enable Unit

This unit collects event pulses from five peripheral sources (two timers, a time-of-day alarm, the serial shift register and an external flag input) into a flag register. It keeps a 5-bit enable mask and drives one registered, active-high interrupt line toward the processor. Software changes the mask through a byte write. Bit 7 of the written byte selects whether the other ones in the byte set enable bits or clear them. Software reads the flags through a destructive read. The read returns the pending sources together with a summary bit, and it clears the flags and the interrupt line in the same step.

Each source asserts its pulse input for one clock per event. A flag is always recorded, whether or not its source is enabled. If a flag is already pending when its enable bit is turned on, the interrupt is raised straight away. An event that arrives in the same cycle as a read is not lost: it stays pending after the read.

Top module: `irq_flag_mask`

## Requirements
- R1: After reset the flags, the summary bit and the mask are all zero. `irq` is low, `rdata` reads 0x00, and a pulse on any source leaves `irq` low.
- R2: A pulse on `src_pulse[i]` sets flag bit i, and `rdata[i]` shows it from the next cycle. The bit mapping is timer A = 0, timer B = 1, alarm = 2, serial = 3, flag pin = 4.
- R3: A pulse on a source whose mask bit is 1 sets the summary bit and asserts `irq` on the next clock edge.
- R4: A pulse on a source whose mask bit is 0 sets only its flag, and `irq` stays low.
- R5: A write (`wr_en`) with `wdata[7]`=1 sets every mask bit i for which `wdata[i]`=1 and leaves the other mask bits unchanged.
- R6: A write with `wdata[7]`=0 clears every mask bit i for which `wdata[i]`=1 and leaves the other mask bits unchanged.
- R7: If a mask write leaves any pending flag enabled, the summary bit is set and `irq` is asserted on the next edge.
- R8: `rdata` is {summary, 2'b00, flags[4:0]}. A read (`rd_en`) samples this value in that cycle, and the next edge clears the flags, the summary bit and `irq`.
- R9: A source pulse in the same cycle as a read survives the clear. If the source is enabled, `irq` stays asserted.
- R10: Once asserted, `irq` stays high until a read, even if the mask is cleared in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 5 | One-cycle event pulses, one per source |
| wr_en | input | 1 | Mask write strobe |
| wdata | input | 8 | Mask write byte; bit 7 selects set or clear |
| rd_en | input | 1 | Destructive read strobe |
| rdata | output | 8 | Summary bit, two zero bits, five flags |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The assertions assume that `rd_en` and `wr_en` are single-cycle strobes sampled on the rising edge. They also assume that a source asserts its pulse for one cycle per event. The properties tied to a mask write exclude cycles that also carry a read, because the read clears state in those cycles. The stimulus drives every input half a cycle away from the active edge. It covers both of these overlaps on purpose: a read together with pulses, and a read together with a write. Each cycle is compared against a reference model, so a property that is excluded from such a cycle is still checked.

// File: rtl/irq_flag_mask.sv
module irq_flag_mask #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pulse,
  input  logic            wr_en,
  input  logic [7:0]      wdata,
  input  logic            rd_en,
  output logic [7:0]      rdata,
  output logic            irq
);
  localparam int PAD = 7 - NSRC;

  logic [NSRC-1:0] flags, mask;
  logic            pend;
  logic [NSRC-1:0] flags_nx, mask_nx;
  logic            pend_nx;

  assign flags_nx = (rd_en ? '0 : flags) | src_pulse;
  assign mask_nx  = !wr_en   ? mask :
                    wdata[7] ? (mask | wdata[NSRC-1:0]) :
                               (mask & ~wdata[NSRC-1:0]);
  assign pend_nx  = (rd_en ? 1'b0 : pend)
                  | (|(src_pulse & mask_nx))
                  | (wr_en && |(flags_nx & mask_nx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
      pend  <= 1'b0;
    end else begin
      flags <= flags_nx;
      mask  <= mask_nx;
      pend  <= pend_nx;
    end
  end

  assign rdata = {pend, {PAD{1'b0}}, flags};
  assign irq   = pend;

  // R2: every pulsed source is visible as a flag one cycle later
  a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((rdata[NSRC-1:0] & $past(src_pulse)) == $past(src_pulse)));

  // R3: an enabled source raises the interrupt
  a_r3_enabled_src: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && |(src_pulse & mask)) |=> irq);

  // R7: enabling a pending flag raises the interrupt
  a_r7_late_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && wdata[7] && |(wdata[NSRC-1:0] & rdata[NSRC-1:0])) |=> irq);

  // R8: a read with no new event clears everything
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && src_pulse == '0) |=> (rdata == 8'h00 && !irq));

  // R10: interrupt holds until read
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_en) |=> irq);

  // R4: the interrupt only rises on an event or a mask write
  a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|src_pulse) || $past(wr_en)));
endmodule

// File: tb/tb_irq_flag_mask.sv
module tb_irq_flag_mask;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] src_pulse = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  int m_flags = 0, m_mask = 0, m_pend = 0;

  always #2.5 clk = ~clk;

  irq_flag_mask dut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq(irq)
  );

  function automatic int exp_rd();
    return (m_pend << 7) | m_flags;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic cyc(input int src, input bit wr, input int wd, input bit rd, input string req);
    int fn, mn;
    src_pulse = src[4:0];
    wr_en = wr;
    wdata = wd[7:0];
    rd_en = rd;
    #1;
    check({req, " rdata"}, int'(rdata), exp_rd());
    fn = (rd ? 0 : m_flags) | (src & 31);
    if (!wr) mn = m_mask;
    else if (wd & 128) mn = m_mask | (wd & 31);
    else mn = m_mask & ~(wd & 31);
    m_pend = ((rd ? 0 : m_pend) != 0 || (src & mn) != 0 || (wr && (fn & mn) != 0)) ? 1 : 0;
    m_flags = fn;
    m_mask = mn;
    @(posedge clk);
    @(negedge clk);
    src_pulse = '0; wr_en = 0; wdata = '0; rd_en = 0;
    check({req, " irq"}, int'(irq), m_pend);
    check({req, " rdata after"}, int'(rdata), exp_rd());
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lf;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", int'(irq), 0);
    check("R1 rdata", int'(rdata), 0);
    rst_n = 1;
    @(negedge clk);
    cyc(5'h1f, 0, 0, 0, "R1 mask zero");
    check("R1 no irq", int'(irq), 0);
    cyc(0, 0, 0, 1, "R8 read all");
    // R4 disabled source
    cyc(5'h02, 0, 0, 0, "R4");
    check("R4 irq low", int'(irq), 0);
    check("R2 timer B bit1", int'(rdata), 8'h02);
    cyc(0, 0, 0, 1, "R8");
    check("R8 cleared", int'(rdata), 0);
    // R5 set mask bit0, R3 enabled source
    cyc(0, 1, 8'h81, 0, "R5");
    cyc(5'h01, 0, 0, 0, "R3");
    check("R3 irq", int'(irq), 1);
    check("R8 summary bit7", int'(rdata), 8'h81);
    cyc(0, 0, 0, 1, "R8");
    check("R8 irq cleared", int'(irq), 0);
    // R6 clear mask bit0
    cyc(0, 1, 8'h01, 0, "R6");
    cyc(5'h01, 0, 0, 0, "R6 disabled");
    check("R6 irq low", int'(irq), 0);
    cyc(0, 0, 0, 1, "R8");
    // R7 late enable of pending alarm
    cyc(5'h04, 0, 0, 0, "R7 pend");
    check("R7 before enable", int'(irq), 0);
    cyc(0, 1, 8'h84, 0, "R7");
    check("R7 irq raised", int'(irq), 1);
    // R10 clearing mask keeps irq
    cyc(0, 1, 8'h04, 0, "R10");
    cyc(0, 0, 0, 0, "R10 idle");
    check("R10 irq held", int'(irq), 1);
    cyc(0, 0, 0, 1, "R8");
    // R9 pulse with read
    cyc(5'h08, 0, 0, 0, "R9 setup");
    cyc(5'h10, 0, 0, 1, "R9");
    check("R9 flag survives", int'(rdata), 8'h10);
    cyc(0, 1, 8'h90, 0, "R9 enable");
    cyc(5'h10, 0, 0, 1, "R9 enabled");
    check("R9 irq survives", int'(irq), 1);
    cyc(0, 0, 0, 1, "R8");
    // R2 each bit position with full mask
    cyc(0, 1, 8'h9f, 0, "R5 all");
    for (int i = 0; i < 5; i++) begin
      cyc(1 << i, 0, 0, 0, "R2");
      check("R2 bit position", int'(rdata), 8'h80 | (1 << i));
      cyc(0, 0, 0, 1, "R8");
    end
    // mixed stream, R3 R6 R7 R8 R9
    lf = 32'h1ace;
    for (int k = 0; k < 400; k++) begin
      lf = (lf << 1) ^ (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1);
      lf = lf & 16'hffff;
      cyc(((lf & 7) == 0) ? (lf >> 3) & 31 : 0, (lf & 48) == 48, lf >> 8,
          (lf & 960) == 960, "R3 R6 R7 R8 R9 mixed");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule